// File: doc/BRIEF.md
# Scanline Playfield Pixel Generator

This block produces the one-bit background playfield pixel for a scanline of 228 color clocks. The first 68 clocks are horizontal blank and the remaining 160 are visible. The visible line splits into two halves of 20 coarse pixels each, and each coarse pixel lasts 4 color clocks. Three pattern registers feed the pixels. Register A holds 4 bits and registers B and C hold 8 bits each.

In the left half the pattern is always drawn as A, then B, then C. In the right half a mode input picks one of two orders:
- **Repeated:** the right half draws the same sequence as the left half.
- **Reflected:** the right half is an exact mirror image of the left half.

A CPU-side write to a pattern register reaches the drawing logic only after a fixed latency of `WR_LAT` color clocks. Software can therefore rewrite a register in the middle of a line and change exactly the pixels it intends. That is how an image whose two halves differ is drawn.

Timing comes from a region state machine with seven states:
- `ST_BLANK`: horizontal blank.
- `ST_LA`, `ST_LB`, `ST_LC`: the three left-half segments.
- `ST_R1`, `ST_R2`, `ST_R3`: the first, second and third right-half segments in drawing order.

Transitions:
- `ST_BLANK`→`ST_LA` on the strobe that ends clock 67.
- `ST_LA`→`ST_LB` after 16 clocks.
- `ST_LB`→`ST_LC` after 32 clocks.
- `ST_LC`→`ST_R1` after 32 clocks. The mode input is captured on this transition.
- `ST_R1`→`ST_R2` after 32 clocks when reflected, or 16 when repeated.
- `ST_R2`→`ST_R3` after 32 clocks.
- `ST_R3`→`ST_BLANK` after 16 clocks when reflected, or 32 when repeated.
- Any state →`ST_BLANK` on a line-start pulse.

Everything advances only on cycles where the color-clock strobe is high.

Top module: `pf_pixel_gen`

## Requirements
- R1: The block keeps a clock number from 0 to 227 that advances by one, wrapping from 227 to 0, on each cycle with `cc_en` high. A `line_start` sampled with `cc_en` sets it to 0. `hblank` is 1 exactly while the clock number is 0 to 67.
- R2: `pf_pixel` is 0 whenever `hblank` is 1.
- R3: In the left half, the pixel source changes with the clock number. Each bit is shown for 4 clocks.
  - Clocks 68–83 show A, where A takes `wr_data[7:4]` when written and its bits are shown 4,5,6,7.
  - Clocks 84–115 show B bits 7 down to 0.
  - Clocks 116–147 show C bits 0 to 7.
- R4: With the captured mode 0 (repeated), clocks 148–227 show the same source and bit sequence as clocks 68–147.
- R5: With the captured mode 1 (reflected), the right half mirrors the left half.
  - Clocks 148–179 show C bits 7 to 0.
  - Clocks 180–211 show B bits 0 to 7.
  - Clocks 212–227 show A data bits 7 to 4.
- R6: `reflect` is sampled only on the strobe that moves the clock number from 147 to 148. A change during the right half has no effect until the next line.
- R7: `reg_wr` strobes select the registers: bit 0 for A, bit 1 for B, bit 2 for C. A write sampled while the clock number is W first affects the pixel at clock W+`WR_LAT` (default 2). The pixel at W+1 still shows the old value.
- R8: While `cc_en` is low, `pf_pixel` and `hblank` hold their values. Write strobes and `line_start` on those cycles are ignored.
- R9: After reset, the clock number is 0, `hblank` is 1, `pf_pixel` is 0 and all three registers are cleared.
- R10: Strobes to several registers in the same cycle all take effect, each from the same `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cc_en | input | 1 | Color-clock strobe; all state advances only when high |
| line_start | input | 1 | Restart the line at clock 0 (sampled with `cc_en`) |
| reg_wr | input | 3 | Write strobes: bit 0 = A, bit 1 = B, bit 2 = C |
| wr_data | input | 8 | Write data; A stores bits 7:4 |
| reflect | input | 1 | Right-half order: 0 repeated, 1 reflected |
| pf_pixel | output | 1 | Playfield pixel for the current color clock |
| hblank | output | 1 | High during horizontal blank clocks 0–67 |

## Verification
On every cycle, the bound checker keeps its own clock count. It checks that the blank window matches that count and that a line start always lands in blank. It also checks that no pixel is lit during blank and that nothing moves on a cycle without the color-clock strobe.

The exact bit order of each segment in both right-half modes can only be shown by the bench's scenarios, which compare every clock of whole lines against an independent model. The same holds for where a mid-line write first lands, including writes two and one clocks before the right half begins. The bench scenarios also cover the mode being latched at the half boundary, and writes that arrive during a stall being dropped.

// File: rtl/pf_pkg.sv
package pf_pkg;

    // Coarse pixel counts of the three pattern registers
    localparam int A_PIX  = 4;
    localparam int BC_PIX = 8;

    typedef enum logic [2:0] {
        ST_BLANK = 3'd0,
        ST_LA    = 3'd1,
        ST_LB    = 3'd2,
        ST_LC    = 3'd3,
        ST_R1    = 3'd4,
        ST_R2    = 3'd5,
        ST_R3    = 3'd6
    } region_e;

endpackage

// File: rtl/pf_write_pipe.sv
module pf_write_pipe #(
    parameter int LAT  = 2,
    parameter int DW   = 8,
    parameter int NREG = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic [NREG-1:0] wr_in,
    input  logic [DW-1:0]   d_in,
    output logic [NREG-1:0] wr_out,
    output logic [DW-1:0]   d_out
);

    // LAT-1 stages in front of the register update give a total of LAT clocks
    localparam int NSTG = (LAT > 1) ? LAT - 1 : 1;

    generate
        if (LAT > 1) begin : g_pipe
            logic [NREG-1:0] stg_wr [NSTG];
            logic [DW-1:0]   stg_d  [NSTG];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < NSTG; i++) begin
                        stg_wr[i] <= '0;
                        stg_d[i]  <= '0;
                    end
                end else if (adv) begin
                    stg_wr[0] <= wr_in;
                    stg_d[0]  <= d_in;
                    for (int i = 1; i < NSTG; i++) begin
                        stg_wr[i] <= stg_wr[i-1];
                        stg_d[i]  <= stg_d[i-1];
                    end
                end
            end

            assign wr_out = stg_wr[NSTG-1];
            assign d_out  = stg_d[NSTG-1];
        end else begin : g_direct
            assign wr_out = wr_in;
            assign d_out  = d_in;
        end
    endgenerate

endmodule

// File: rtl/pf_pattern_regs.sv
module pf_pattern_regs #(
    parameter int AW = 4,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [2:0]    wr,
    input  logic [BW-1:0] d,
    output logic [AW-1:0] reg_a,
    output logic [BW-1:0] reg_b,
    output logic [BW-1:0] reg_c
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_a <= '0;
            reg_b <= '0;
            reg_c <= '0;
        end else if (adv) begin
            if (wr[0]) reg_a <= d[BW-1 -: AW];
            if (wr[1]) reg_b <= d;
            if (wr[2]) reg_c <= d;
        end
    end

endmodule

// File: rtl/pf_region_fsm.sv
module pf_region_fsm
    import pf_pkg::*;
#(
    parameter int PIX_CLKS   = 4,
    parameter int BLANK_CLKS = 68,
    parameter int LINE_CLKS  = 228,
    parameter int POS_W      = 8,
    parameter int SEG_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             line_start,
    input  logic             mode_in,
    output region_e          region,
    output logic [SEG_W-1:0] seg_cnt,
    output logic             mirror
);

    localparam int A_LEN  = A_PIX * PIX_CLKS;
    localparam int BC_LEN = BC_PIX * PIX_CLKS;

    localparam logic [SEG_W-1:0] A_LAST  = SEG_W'(A_LEN - 1);
    localparam logic [SEG_W-1:0] BC_LAST = SEG_W'(BC_LEN - 1);
    localparam logic [POS_W-1:0] POS_END = POS_W'(LINE_CLKS - 1);
    localparam logic [POS_W-1:0] BLK_END = POS_W'(BLANK_CLKS - 1);

    region_e          st_q, st_nx;
    logic [SEG_W-1:0] cnt_q, cnt_nx;
    logic [POS_W-1:0] pos_q, pos_nx;
    logic             mir_q, mir_nx;
    logic [SEG_W-1:0] r1_last, r3_last;

    assign r1_last = mir_q ? BC_LAST : A_LAST;
    assign r3_last = mir_q ? A_LAST  : BC_LAST;

    // Next-state logic
    always_comb begin
        st_nx  = st_q;
        cnt_nx = cnt_q + 1'b1;
        mir_nx = mir_q;
        pos_nx = (pos_q == POS_END) ? '0 : pos_q + 1'b1;
        unique case (st_q)
            ST_BLANK: begin
                cnt_nx = '0;
                if (pos_q == BLK_END) st_nx = ST_LA;
            end
            ST_LA: begin
                if (cnt_q == A_LAST) begin
                    st_nx  = ST_LB;
                    cnt_nx = '0;
                end
            end
            ST_LB: begin
                if (cnt_q == BC_LAST) begin
                    st_nx  = ST_LC;
                    cnt_nx = '0;
                end
            end
            ST_LC: begin
                if (cnt_q == BC_LAST) begin
                    st_nx  = ST_R1;
                    cnt_nx = '0;
                    mir_nx = mode_in;
                end
            end
            ST_R1: begin
                if (cnt_q == r1_last) begin
                    st_nx  = ST_R2;
                    cnt_nx = '0;
                end
            end
            ST_R2: begin
                if (cnt_q == BC_LAST) begin
                    st_nx  = ST_R3;
                    cnt_nx = '0;
                end
            end
            ST_R3: begin
                if (cnt_q == r3_last) begin
                    st_nx  = ST_BLANK;
                    cnt_nx = '0;
                end
            end
            default: begin
                st_nx  = ST_BLANK;
                cnt_nx = '0;
            end
        endcase
        if (line_start) begin
            st_nx  = ST_BLANK;
            cnt_nx = '0;
            pos_nx = '0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_BLANK;
            cnt_q <= '0;
            pos_q <= '0;
            mir_q <= 1'b0;
        end else if (adv) begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
            pos_q <= pos_nx;
            mir_q <= mir_nx;
        end
    end

    assign region  = st_q;
    assign seg_cnt = cnt_q;
    assign mirror  = mir_q;

endmodule

// File: rtl/pf_pixel_mux.sv
module pf_pixel_mux
    import pf_pkg::*;
#(
    parameter int PIX_CLKS = 4,
    parameter int SEG_W    = 5
) (
    input  region_e          region,
    input  logic [SEG_W-1:0] seg_cnt,
    input  logic             mirror,
    input  logic [3:0]       reg_a,
    input  logic [7:0]       reg_b,
    input  logic [7:0]       reg_c,
    output logic             pixel,
    output logic             blank
);

    logic [2:0] idx;
    logic [2:0] ridx;

    assign idx  = 3'(seg_cnt / SEG_W'(PIX_CLKS));
    assign ridx = ~idx;

    // Output process: source and bit direction per region
    always_comb begin
        pixel = 1'b0;
        blank = 1'b0;
        unique case (region)
            ST_BLANK: blank = 1'b1;
            ST_LA:    pixel = reg_a[idx[1:0]];
            ST_LB:    pixel = reg_b[ridx];
            ST_LC:    pixel = reg_c[idx];
            ST_R1:    pixel = mirror ? reg_c[ridx] : reg_a[idx[1:0]];
            ST_R2:    pixel = mirror ? reg_b[idx]  : reg_b[ridx];
            ST_R3:    pixel = mirror ? reg_a[ridx[1:0]] : reg_c[idx];
            default:  blank = 1'b1;
        endcase
    end

endmodule

// File: rtl/pf_pixel_gen.sv
module pf_pixel_gen
    import pf_pkg::*;
#(
    parameter int WR_LAT     = 2,
    parameter int PIX_CLKS   = 4,
    parameter int BLANK_CLKS = 68
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cc_en,
    input  logic       line_start,
    input  logic [2:0] reg_wr,
    input  logic [7:0] wr_data,
    input  logic       reflect,
    output logic       pf_pixel,
    output logic       hblank
);

    localparam int LINE_CLKS = BLANK_CLKS + 2 * PIX_CLKS * (A_PIX + 2 * BC_PIX);
    localparam int POS_W     = $clog2(LINE_CLKS);
    localparam int SEG_W     = $clog2(BC_PIX * PIX_CLKS);

    logic [2:0]       dly_wr;
    logic [7:0]       dly_d;
    logic [3:0]       reg_a;
    logic [7:0]       reg_b;
    logic [7:0]       reg_c;
    region_e          region;
    logic [SEG_W-1:0] seg_cnt;
    logic             mirror;

    pf_write_pipe #(
        .LAT  (WR_LAT),
        .DW   (8),
        .NREG (3)
    ) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (cc_en),
        .wr_in  (reg_wr),
        .d_in   (wr_data),
        .wr_out (dly_wr),
        .d_out  (dly_d)
    );

    pf_pattern_regs #(
        .AW (4),
        .BW (8)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (cc_en),
        .wr    (dly_wr),
        .d     (dly_d),
        .reg_a (reg_a),
        .reg_b (reg_b),
        .reg_c (reg_c)
    );

    pf_region_fsm #(
        .PIX_CLKS   (PIX_CLKS),
        .BLANK_CLKS (BLANK_CLKS),
        .LINE_CLKS  (LINE_CLKS),
        .POS_W      (POS_W),
        .SEG_W      (SEG_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (cc_en),
        .line_start (line_start),
        .mode_in    (reflect),
        .region     (region),
        .seg_cnt    (seg_cnt),
        .mirror     (mirror)
    );

    pf_pixel_mux #(
        .PIX_CLKS (PIX_CLKS),
        .SEG_W    (SEG_W)
    ) u_mux (
        .region  (region),
        .seg_cnt (seg_cnt),
        .mirror  (mirror),
        .reg_a   (reg_a),
        .reg_b   (reg_b),
        .reg_c   (reg_c),
        .pixel   (pf_pixel),
        .blank   (hblank)
    );

endmodule

// File: rtl/pf_pixel_gen_checker.sv
module pf_pixel_gen_checker #(
    parameter int BLANK_CLKS = 68,
    parameter int LINE_CLKS  = 228
) (
    input logic clk,
    input logic rst_n,
    input logic cc_en,
    input logic line_start,
    input logic pf_pixel,
    input logic hblank
);

    localparam int CW = $clog2(LINE_CLKS);

    logic [CW-1:0] clk_no;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            clk_no <= '0;
        else if (cc_en)
            clk_no <= line_start ? '0 :
                      (clk_no == CW'(LINE_CLKS - 1)) ? '0 : clk_no + 1'b1;
    end

    assert_blank_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hblank == (clk_no < CW'(BLANK_CLKS)));

    assert_restart_blank_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_en && line_start) |=> hblank);

    assert_dark_in_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hblank |-> !pf_pixel);

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_en |=> ($stable(pf_pixel) && $stable(hblank)));

endmodule

bind pf_pixel_gen pf_pixel_gen_checker chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cc_en      (cc_en),
    .line_start (line_start),
    .pf_pixel   (pf_pixel),
    .hblank     (hblank)
);

// File: tb/pf_pixel_gen_test.sv
module pf_pixel_gen_test;

    localparam int LAT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cc_en = 1'b0;
    logic       line_start = 1'b0;
    logic [2:0] reg_wr = '0;
    logic [7:0] wr_data = '0;
    logic       reflect = 1'b0;
    logic       pf_pixel;
    logic       hblank;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pf_pixel_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cc_en      (cc_en),
        .line_start (line_start),
        .reg_wr     (reg_wr),
        .wr_data    (wr_data),
        .reflect    (reflect),
        .pf_pixel   (pf_pixel),
        .hblank     (hblank)
    );

    // ---------------- reference model ----------------
    typedef struct {int due; logic [2:0] wr; logic [7:0] d;} pw_t;
    typedef struct {bit pix; bit blk; int h; string tag;} exp_t;

    pw_t  pend[$];
    exp_t sb[$];
    int         m_pos = 0;
    int         ecount = 0;
    bit         m_mir = 0;
    logic [3:0] m_a = '0;
    logic [7:0] m_b = '0;
    logic [7:0] m_c = '0;

    function automatic void model_edge(logic [2:0] wr, logic [7:0] d, bit ls, bit md);
        int i;
        ecount++;
        if (wr != 3'b000) pend.push_back('{ecount + LAT - 1, wr, d});
        i = 0;
        while (i < pend.size()) begin
            if (pend[i].due == ecount) begin
                if (pend[i].wr[0]) m_a = pend[i].d[7:4];
                if (pend[i].wr[1]) m_b = pend[i].d;
                if (pend[i].wr[2]) m_c = pend[i].d;
                pend.delete(i);
            end else i++;
        end
        m_pos = ls ? 0 : ((m_pos == 227) ? 0 : m_pos + 1);
        if (!ls && m_pos == 148) m_mir = md;
    endfunction

    function automatic bit exp_pix();
        int p, q, l;
        if (m_pos < 68) return 1'b0;
        p = m_pos - 68;
        if (p < 80) l = p / 4;
        else begin
            q = p - 80;
            l = m_mir ? 19 - q / 4 : q / 4;
        end
        if (l < 4)  return m_a[l];
        if (l < 12) return m_b[11 - l];
        return m_c[l - 12];
    endfunction

    function automatic string region_tag();
        if (m_pos < 68)  return "R2";
        if (m_pos < 148) return "R3";
        return m_mir ? "R5" : "R4";
    endfunction

    // ---------------- driver ----------------
    task automatic step(bit en, logic [2:0] wr, logic [7:0] d, bit ls, bit md, string tag);
        exp_t e;
        cc_en = en; reg_wr = wr; wr_data = d; line_start = ls; reflect = md;
        @(posedge clk);
        #1;
        if (en) model_edge(wr, d, ls, md);
        e.pix = exp_pix();
        e.blk = (m_pos < 68);
        e.h   = m_pos;
        e.tag = (tag == "") ? region_tag() : tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic adv_to(int target, bit md, string tag);
        do step(1, 3'b000, 8'h00, 0, md, tag); while (m_pos != target);
    endtask

    task automatic whole_line(bit md, string tag);
        step(1, 3'b000, 8'h00, 1, md, tag);
        adv_to(0, md, tag);
    endtask

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        exp_t e;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            n_checks += 2;
            if (pf_pixel !== e.pix) begin
                n_fail++;
                $display("FAIL %s clock %0d: pf_pixel actual %b expected %b", e.tag, e.h, pf_pixel, e.pix);
            end
            if (hblank !== e.blk) begin
                n_fail++;
                $display("FAIL R1 clock %0d: hblank actual %b expected %b", e.h, hblank, e.blk);
            end
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        n_checks += 2;
        if (hblank !== 1'b1) begin n_fail++; $display("FAIL R9: hblank actual %b expected 1", hblank); end
        if (pf_pixel !== 1'b0) begin n_fail++; $display("FAIL R9: pf_pixel actual %b expected 0", pf_pixel); end
        rst_n = 1'b1;
        @(negedge clk);

        // R9: registers cleared, whole line dark
        whole_line(0, "R9");

        // R10: simultaneous write of all three registers
        step(1, 3'b000, 8'h00, 1, 0, "R10");
        step(1, 3'b111, 8'hA5, 0, 0, "R10");
        adv_to(0, 0, "R10");

        // Distinct patterns, repeated then reflected (R3, R4, R5)
        step(1, 3'b000, 8'h00, 1, 0, "");
        step(1, 3'b010, 8'h5C, 0, 0, "");
        step(1, 3'b100, 8'h3E, 0, 0, "");
        step(1, 3'b001, 8'h60, 0, 0, "");
        adv_to(0, 0, "");
        whole_line(0, "");
        whole_line(1, "");

        // R6: mode change inside right half has no effect
        step(1, 3'b000, 8'h00, 1, 1, "R6");
        adv_to(160, 1, "R6");
        adv_to(0, 0, "R6");
        whole_line(0, "R6");

        // R7: mid-line writes landing at exact clocks
        step(1, 3'b000, 8'h00, 1, 0, "R7");
        adv_to(100, 0, "R7");
        step(1, 3'b010, 8'hA3, 0, 0, "R7");
        adv_to(146, 0, "R7");
        step(1, 3'b001, 8'h90, 0, 0, "R7");
        step(1, 3'b100, 8'hC1, 0, 0, "R7");
        adv_to(0, 0, "R7");

        // R8: stall with strobes and line_start ignored
        step(1, 3'b000, 8'h00, 1, 1, "R8");
        adv_to(120, 1, "R8");
        for (int k = 0; k < 6; k++) step(0, 3'b111, 8'hFF, 1, 1, "R8");
        adv_to(0, 1, "R8");
        whole_line(1, "R8");

        step(1, 3'b000, 8'h00, 0, 0, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule